// File: doc/BRIEF.md
# Write-Merging Store Buffer

This block sits between a core's store path and a 64-bit AXI write port for Normal memory that is non-cacheable or write-through. Stores arrive one 8-byte beat at a time, with a byte strobe. Each store either joins a buffered entry that covers the same 32-byte line, or it takes a free entry. Each entry holds a line address, 32 data bytes and one valid bit per byte. A store that lands on bytes already buffered replaces them.

An entry drains in two cases: when it has gone a set number of cycles without a merge, or when every entry is occupied. It drains as one INCR burst. The burst runs from the first 8-byte beat that holds data to the last one. Bytes that no store wrote go out with their strobe low, so scattered stores still cost one burst. Entries cover distinct lines, so they may leave in any order. The entry is released when its write response arrives.

A store that targets the line of an entry being drained waits until that entry is released. This keeps program order between stores to the same line.

Top module: `store_merge_buf`

## Requirements
- R1: While and after reset, with no store pending, `aw_valid_o` and `w_valid_o` are low and `st_ready_o` is high.
- R2: The line of a store is address bits [ADDR_W-1:5] and its beat is bits [4:3]; bits [2:0] are ignored. A store whose line matches a buffered entry that is not draining is merged into that entry. All stores merged into one entry leave in a single burst.
- R3: Where a store's strobe covers bytes already buffered, the newer bytes replace the older ones. Memory seen through the write port ends with, for each byte, the value of the last store to it.
- R4: A burst covers the first through the last beat of the line that holds any valid byte. `aw_addr_o` is the line base plus 8 times the first beat, `aw_len_o` is the last beat minus the first, and `w_last_o` marks the final beat. The first and final beats each carry a nonzero strobe.
- R5: Inside the burst span, bytes that no store wrote are sent with their strobe bit low, including whole empty beats between written ones.
- R6: Every burst has `aw_size_o` = 3 (8 bytes) and `aw_burst_o` = 2'b01 (INCR). Address and length stay stable while `aw_valid_o` waits for `aw_ready_i`.
- R7: An entry whose last merge or allocation was accepted at clock edge E raises `aw_valid_o` after edge E+HOLD+1, not before. When all entries are occupied, a drain starts on the next edge whatever the ages. Entries may drain in an order that differs from arrival.
- R8: With every entry occupied, a store to a line no entry holds sees `st_ready_o` low. A store to the line of an occupied entry that is not draining sees `st_ready_o` high.
- R9: A store to the line of an entry being drained sees `st_ready_o` low, so no two entries ever hold the same line.
- R10: An entry is freed by the handshake on `b_valid_i`/`b_ready_o`. After that, a store to its line is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request valid |
| st_ready_o | output | 1 | Store accepted this cycle when high with valid |
| st_addr_i | input | ADDR_W | Store byte address; bits [2:0] ignored |
| st_data_i | input | 64 | Store data for one beat |
| st_strb_i | input | 8 | Byte enables of the store beat |
| aw_valid_o | output | 1 | Write address valid |
| aw_ready_i | input | 1 | Write address ready |
| aw_addr_o | output | ADDR_W | Burst start address, beat aligned |
| aw_len_o | output | 8 | Beats minus one |
| aw_size_o | output | 3 | Beat size code, always 3 |
| aw_burst_o | output | 2 | Burst type, always INCR |
| w_valid_o | output | 1 | Write data valid |
| w_ready_i | input | 1 | Write data ready |
| w_data_o | output | 64 | Write data beat |
| w_strb_o | output | 8 | Byte strobes of the beat |
| w_last_o | output | 1 | Final beat of the burst |
| b_valid_i | input | 1 | Write response valid |
| b_ready_o | output | 1 | Write response ready |

## Verification
The bench builds the buffer with four entries and a hold time of six cycles. Four distinct lines are then enough to fill the buffer, and a stalled address channel keeps one entry draining, so the full-buffer stall, the merge-while-full case and the stall on a draining line can each be probed in turn. The short hold lets the age-triggered drain be timed cycle by cycle. Random traffic spread over eight lines, twice the entry count, makes full-buffer drains and out-of-order departures frequent under random ready and response timing.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int LINE_BYTES = 32;
  localparam int BEAT_BYTES = 8;
  localparam int BEATS      = LINE_BYTES / BEAT_BYTES;
  localparam int BEAT_W     = $clog2(BEATS);
  localparam int BYTE_W     = $clog2(BEAT_BYTES);
  localparam int LINE_OFS   = $clog2(LINE_BYTES);
  localparam int DATA_W     = BEAT_BYTES * 8;

  typedef enum logic [1:0] {
    DR_IDLE,
    DR_ADDR,
    DR_DATA,
    DR_RESP
  } drain_st_e;
endpackage

// File: rtl/smb_entry.sv
module smb_entry
  import smb_pkg::*;
#(
  parameter int LINE_W = 27,
  parameter int HOLD   = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    alloc_i,
  input  logic                    wr_i,
  input  logic [LINE_W-1:0]       line_i,
  input  logic [BEAT_W-1:0]       beat_i,
  input  logic [DATA_W-1:0]       data_i,
  input  logic [BEAT_BYTES-1:0]   strb_i,
  input  logic                    lock_i,
  input  logic                    free_i,
  output logic                    valid_o,
  output logic                    locked_o,
  output logic                    aged_o,
  output logic [LINE_W-1:0]       line_o,
  output logic [LINE_BYTES*8-1:0] data_o,
  output logic [LINE_BYTES-1:0]   bval_o
);
  localparam int CNT_W = $clog2(HOLD + 1);

  logic                           valid_q, locked_q;
  logic [LINE_W-1:0]              line_q;
  logic [LINE_BYTES-1:0][7:0]     data_q;
  logic [LINE_BYTES-1:0]          bval_q;
  logic [CNT_W-1:0]               cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      locked_q <= 1'b0;
      line_q   <= '0;
      data_q   <= '0;
      bval_q   <= '0;
      cnt_q    <= '0;
    end else if (free_i) begin
      valid_q  <= 1'b0;
      locked_q <= 1'b0;
      bval_q   <= '0;
    end else begin
      if (alloc_i) begin
        valid_q <= 1'b1;
        line_q  <= line_i;
      end
      if (lock_i) locked_q <= 1'b1;
      // age restarts on every write; saturates at HOLD
      if (wr_i) cnt_q <= '0;
      else if (valid_q && !locked_q && cnt_q != CNT_W'(HOLD)) cnt_q <= cnt_q + 1'b1;
      for (int k = 0; k < LINE_BYTES; k++) begin
        if (wr_i && beat_i == BEAT_W'(k / BEAT_BYTES) && strb_i[k % BEAT_BYTES]) begin
          bval_q[k] <= 1'b1;
          data_q[k] <= data_i[(k % BEAT_BYTES)*8 +: 8];
        end else if (alloc_i) begin
          bval_q[k] <= 1'b0;
        end
      end
    end
  end

  assign valid_o  = valid_q;
  assign locked_o = locked_q;
  assign aged_o   = valid_q && (cnt_q == CNT_W'(HOLD));
  assign line_o   = line_q;
  assign data_o   = data_q;
  assign bval_o   = bval_q;

  // R9: a draining entry is always occupied
  a_r9_lock_in_use: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |-> valid_q);
  // R2: an occupied entry always holds data
  a_r2_entry_not_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> (bval_q != '0));
endmodule

// File: rtl/smb_span.sv
module smb_span
  import smb_pkg::*;
(
  input  logic [LINE_BYTES-1:0] bval_i,
  output logic [BEAT_W-1:0]     first_o,
  output logic [BEAT_W-1:0]     last_o
);
  always_comb begin
    first_o = '0;
    last_o  = '0;
    for (int k = BEATS - 1; k >= 0; k--)
      if (|bval_i[k*BEAT_BYTES +: BEAT_BYTES]) first_o = BEAT_W'(k);
    for (int k = 0; k < BEATS; k++)
      if (|bval_i[k*BEAT_BYTES +: BEAT_BYTES]) last_o = BEAT_W'(k);
  end
endmodule

// File: rtl/smb_drain.sv
module smb_drain
  import smb_pkg::*;
#(
  parameter int N_ENT  = 4,
  parameter int ADDR_W = 32,
  parameter int SEL_W  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_ENT-1:0]        cand_i,
  input  logic [ADDR_W-LINE_OFS-1:0] line_i,
  input  logic [LINE_BYTES*8-1:0] data_i,
  input  logic [LINE_BYTES-1:0]   bval_i,
  output logic [SEL_W-1:0]        sel_o,
  output logic [N_ENT-1:0]        lock_o,
  output logic [N_ENT-1:0]        free_o,
  output logic                    aw_valid_o,
  input  logic                    aw_ready_i,
  output logic [ADDR_W-1:0]       aw_addr_o,
  output logic [7:0]              aw_len_o,
  output logic [2:0]              aw_size_o,
  output logic [1:0]              aw_burst_o,
  output logic                    w_valid_o,
  input  logic                    w_ready_i,
  output logic [DATA_W-1:0]       w_data_o,
  output logic [BEAT_BYTES-1:0]   w_strb_o,
  output logic                    w_last_o,
  input  logic                    b_valid_i,
  output logic                    b_ready_o
);
  drain_st_e           st_q;
  logic [SEL_W-1:0]    sel_q, pick_idx;
  logic                pick_ok;
  logic [BEAT_W-1:0]   beat_q, first_b, last_b;

  smb_span u_span (.bval_i(bval_i), .first_o(first_b), .last_o(last_b));

  // lowest-index candidate wins; lines are distinct so order is free
  always_comb begin
    pick_ok  = 1'b0;
    pick_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (cand_i[i]) begin
        pick_ok  = 1'b1;
        pick_idx = SEL_W'(i);
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= DR_IDLE;
      sel_q  <= '0;
      beat_q <= '0;
    end else begin
      unique case (st_q)
        DR_IDLE: if (pick_ok) begin
          sel_q <= pick_idx;
          st_q  <= DR_ADDR;
        end
        DR_ADDR: if (aw_ready_i) begin
          beat_q <= first_b;
          st_q   <= DR_DATA;
        end
        DR_DATA: if (w_ready_i) begin
          if (beat_q == last_b) st_q <= DR_RESP;
          else beat_q <= beat_q + 1'b1;
        end
        DR_RESP: if (b_valid_i) st_q <= DR_IDLE;
        default: st_q <= DR_IDLE;
      endcase
    end
  end

  assign sel_o      = sel_q;
  assign lock_o     = (st_q == DR_IDLE && pick_ok) ? (N_ENT'(1) << pick_idx) : '0;
  assign free_o     = (st_q == DR_RESP && b_valid_i) ? (N_ENT'(1) << sel_q) : '0;
  assign aw_valid_o = (st_q == DR_ADDR);
  assign aw_addr_o  = {line_i, first_b, {BYTE_W{1'b0}}};
  assign aw_len_o   = 8'(last_b - first_b);
  assign aw_size_o  = 3'(BYTE_W);
  assign aw_burst_o = 2'b01;
  assign w_valid_o  = (st_q == DR_DATA);
  assign w_data_o   = data_i[beat_q*DATA_W +: DATA_W];
  assign w_strb_o   = bval_i[beat_q*BEAT_BYTES +: BEAT_BYTES];
  assign w_last_o   = (beat_q == last_b);
  assign b_ready_o  = (st_q == DR_RESP);

  a_r6_aw_attrs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aw_valid_o |-> (aw_size_o == 3'd3 && aw_burst_o == 2'b01));
  a_r6_aw_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aw_valid_o && !aw_ready_i) |=> (aw_valid_o && $stable(aw_addr_o) && $stable(aw_len_o)));
  a_r4_final_beat_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_valid_o && w_last_o) |-> (w_strb_o != '0));
  a_r4_len_in_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aw_valid_o |-> (aw_len_o < 8'(BEATS)));
  a_r10_one_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(free_o) && $onehot0(lock_o));
endmodule

// File: rtl/store_merge_buf.sv
module store_merge_buf
  import smb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_ENT  = 4,
  parameter int HOLD   = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  st_valid_i,
  output logic                  st_ready_o,
  input  logic [ADDR_W-1:0]     st_addr_i,
  input  logic [DATA_W-1:0]     st_data_i,
  input  logic [BEAT_BYTES-1:0] st_strb_i,
  output logic                  aw_valid_o,
  input  logic                  aw_ready_i,
  output logic [ADDR_W-1:0]     aw_addr_o,
  output logic [7:0]            aw_len_o,
  output logic [2:0]            aw_size_o,
  output logic [1:0]            aw_burst_o,
  output logic                  w_valid_o,
  input  logic                  w_ready_i,
  output logic [DATA_W-1:0]     w_data_o,
  output logic [BEAT_BYTES-1:0] w_strb_o,
  output logic                  w_last_o,
  input  logic                  b_valid_i,
  output logic                  b_ready_o
);
  localparam int LINE_W = ADDR_W - LINE_OFS;
  localparam int SEL_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  logic [LINE_W-1:0]        st_line;
  logic [BEAT_W-1:0]        st_beat;
  logic                     unused_lo;
  logic [N_ENT-1:0]         ent_valid, ent_locked, ent_aged, hit, alloc_oh;
  logic [N_ENT-1:0]         ent_alloc, ent_wr, lock_v, free_v, cand;
  logic [LINE_W-1:0]        ent_line [N_ENT];
  logic [LINE_BYTES*8-1:0]  ent_data [N_ENT];
  logic [LINE_BYTES-1:0]    ent_bval [N_ENT];
  logic                     hit_any, hit_open, has_free, full, st_fire;
  logic [SEL_W-1:0]         sel;
  logic [LINE_W-1:0]        sel_line;
  logic [LINE_BYTES*8-1:0]  sel_data;
  logic [LINE_BYTES-1:0]    sel_bval;

  assign st_line   = st_addr_i[ADDR_W-1:LINE_OFS];
  assign st_beat   = st_addr_i[LINE_OFS-1:BYTE_W];
  assign unused_lo = ^st_addr_i[BYTE_W-1:0];

  always_comb begin
    alloc_oh = '0;
    for (int i = N_ENT - 1; i >= 0; i--)
      if (!ent_valid[i]) alloc_oh = N_ENT'(1) << i;
  end

  assign hit_any    = |hit;
  assign hit_open   = |(hit & ~ent_locked);
  assign has_free   = ~&ent_valid;
  assign full       = &ent_valid;
  // same-line store waits while its entry drains
  assign st_ready_o = hit_open || (!hit_any && has_free);
  assign st_fire    = st_valid_i && st_ready_o;
  assign ent_alloc  = (st_fire && !hit_any) ? alloc_oh : '0;
  assign ent_wr     = !st_fire ? '0 : (hit_any ? hit : alloc_oh);
  assign cand       = ent_valid & ~ent_locked & (ent_aged | {N_ENT{full}});

  for (genvar gi = 0; gi < N_ENT; gi++) begin : g_ent
    assign hit[gi] = ent_valid[gi] && (ent_line[gi] == st_line);
    smb_entry #(.LINE_W(LINE_W), .HOLD(HOLD)) u_ent (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .alloc_i  (ent_alloc[gi]),
      .wr_i     (ent_wr[gi]),
      .line_i   (st_line),
      .beat_i   (st_beat),
      .data_i   (st_data_i),
      .strb_i   (st_strb_i),
      .lock_i   (lock_v[gi]),
      .free_i   (free_v[gi]),
      .valid_o  (ent_valid[gi]),
      .locked_o (ent_locked[gi]),
      .aged_o   (ent_aged[gi]),
      .line_o   (ent_line[gi]),
      .data_o   (ent_data[gi]),
      .bval_o   (ent_bval[gi])
    );
  end

  always_comb begin
    sel_line = '0;
    sel_data = '0;
    sel_bval = '0;
    for (int i = 0; i < N_ENT; i++)
      if (sel == SEL_W'(i)) begin
        sel_line = ent_line[i];
        sel_data = ent_data[i];
        sel_bval = ent_bval[i];
      end
  end

  smb_drain #(.N_ENT(N_ENT), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_drain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cand_i     (cand),
    .line_i     (sel_line),
    .data_i     (sel_data),
    .bval_i     (sel_bval),
    .sel_o      (sel),
    .lock_o     (lock_v),
    .free_o     (free_v),
    .aw_valid_o (aw_valid_o),
    .aw_ready_i (aw_ready_i),
    .aw_addr_o  (aw_addr_o),
    .aw_len_o   (aw_len_o),
    .aw_size_o  (aw_size_o),
    .aw_burst_o (aw_burst_o),
    .w_valid_o  (w_valid_o),
    .w_ready_i  (w_ready_i),
    .w_data_o   (w_data_o),
    .w_strb_o   (w_strb_o),
    .w_last_o   (w_last_o),
    .b_valid_i  (b_valid_i),
    .b_ready_o  (b_ready_o)
  );

  for (genvar gi = 0; gi < N_ENT; gi++) begin : g_uniq
    for (genvar gj = gi + 1; gj < N_ENT; gj++) begin : g_pair
      a_r9_unique_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ent_valid[gi] && ent_valid[gj] && ent_line[gi] == ent_line[gj]));
    end
  end

  a_r8_full_blocks_new: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && full && !hit_any) |-> !st_ready_o);
  a_r9_draining_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && |(hit & ent_locked)) |-> !st_ready_o);
  a_r10_resp_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_valid_i && b_ready_o) |=> !$stable(ent_valid));
endmodule

// File: tb/sim_store_merge_buf.sv
`timescale 1ns/1ps
module sim_store_merge_buf;
  localparam int AW = 32;
  localparam int NE = 4;
  localparam int HOLD = 6;
  localparam int NLINES = 8;
  localparam logic [31:0] BASE = 32'h1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 1'b0, st_ready;
  logic [AW-1:0] st_addr = '0;
  logic [63:0] st_data = '0;
  logic [7:0] st_strb = '0;
  logic aw_valid, aw_ready, w_valid, w_ready, w_last, b_valid, b_ready;
  logic [AW-1:0] aw_addr;
  logic [7:0] aw_len, w_strb;
  logic [2:0] aw_size;
  logic [1:0] aw_burst;
  logic [63:0] w_data;

  always #10 clk = ~clk;

  store_merge_buf #(.ADDR_W(AW), .N_ENT(NE), .HOLD(HOLD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .st_valid_i(st_valid), .st_ready_o(st_ready),
    .st_addr_i(st_addr), .st_data_i(st_data), .st_strb_i(st_strb),
    .aw_valid_o(aw_valid), .aw_ready_i(aw_ready), .aw_addr_o(aw_addr),
    .aw_len_o(aw_len), .aw_size_o(aw_size), .aw_burst_o(aw_burst),
    .w_valid_o(w_valid), .w_ready_i(w_ready), .w_data_o(w_data),
    .w_strb_o(w_strb), .w_last_o(w_last), .b_valid_i(b_valid), .b_ready_o(b_ready));

  int vectors = 0, errors = 0;
  logic [7:0] ref_mem [NLINES*32];
  logic [7:0] slv_mem [NLINES*32];
  int slave_mode = 0, pend = 0, bursts = 0, beat_cnt = 0, cur_off = 0, last_len = 0;
  logic [31:0] last_aw = '0;
  logic [7:0] last_strb [4];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] addr_of(input int line, input int beat);
    return BASE + 32'(line*32 + beat*8);
  endfunction

  task automatic do_store(input int line, input int beat, input logic [63:0] d, input logic [7:0] s);
    @(negedge clk);
    st_valid = 1'b1; st_addr = addr_of(line, beat); st_data = d; st_strb = s;
    #1;
    while (!st_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    st_valid = 1'b0;
    for (int b = 0; b < 8; b++)
      if (s[b]) ref_mem[line*32 + beat*8 + b] = d[b*8 +: 8];
  endtask

  task automatic probe(input int line, output bit rdy);
    @(negedge clk);
    st_valid = 1'b1; st_addr = addr_of(line, 0); st_strb = 8'h01;
    #1;
    rdy = st_ready;
    st_valid = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (HOLD*4 + 60) @(negedge clk);
  endtask

  // AXI write slave
  initial begin
    aw_ready = 1'b0; w_ready = 1'b0; b_valid = 1'b0;
    forever begin
      @(negedge clk);
      case (slave_mode)
        0: begin aw_ready = 1'b0; w_ready = 1'b0; end
        1: begin aw_ready = 1'b1; w_ready = 1'b1; end
        default: begin aw_ready = 1'($urandom_range(0, 1)); w_ready = 1'($urandom_range(0, 1)); end
      endcase
      b_valid = (pend > 0) && (slave_mode != 2 || $urandom_range(0, 1) == 1);
      #1;
      if (aw_valid && aw_ready) begin
        bursts++; last_aw = aw_addr; last_len = int'(aw_len); beat_cnt = 0;
        cur_off = int'(aw_addr - BASE);
        chk(aw_size == 3'd3 && aw_burst == 2'b01, "R6 size/burst", {aw_size, aw_burst}, {3'd3, 2'b01});
        chk(aw_addr[2:0] == 3'd0 && (int'(aw_addr[4:3]) + int'(aw_len)) <= 3, "R4 span in line",
            {aw_addr, aw_len}, {aw_addr[31:3], 3'd0, 8'd3});
      end
      if (w_valid && w_ready) begin
        last_strb[beat_cnt & 3] = w_strb;
        for (int b = 0; b < 8; b++)
          if (w_strb[b] && (cur_off + beat_cnt*8 + b) < NLINES*32)
            slv_mem[cur_off + beat_cnt*8 + b] = w_data[b*8 +: 8];
        chk(w_last == (beat_cnt == last_len), "R4 w_last position", w_last, 64'(beat_cnt == last_len));
        if (beat_cnt == 0) chk(w_strb != 8'h00, "R4 first beat strobe", w_strb, 64'hff);
        if (w_last) begin
          chk(w_strb != 8'h00, "R4 final beat strobe", w_strb, 64'hff);
          pend++;
        end
        beat_cnt++;
      end
      if (b_valid && b_ready) pend--;
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int b0, locked_line, other;
    bit rdy, ok;
    void'($urandom(32'd7341));
    for (int i = 0; i < NLINES*32; i++) begin ref_mem[i] = 8'h00; slv_mem[i] = 8'h00; end
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(!aw_valid && !w_valid && st_ready, "R1 reset outputs", {aw_valid, w_valid, st_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!aw_valid && !w_valid && st_ready, "R1 after reset", {aw_valid, w_valid, st_ready}, 3'b001);
    slave_mode = 1;

    // R7: age-triggered drain timing
    do_store(0, 1, 64'h1122334455667788, 8'hff);
    repeat (HOLD + 1) @(negedge clk);
    chk(!aw_valid, "R7 no drain before hold", aw_valid, 0);
    @(negedge clk);
    chk(aw_valid, "R7 drain after hold", aw_valid, 1);
    wait_idle();

    // R2 + R5: two stores merge, hole beat in middle
    b0 = bursts;
    do_store(1, 0, 64'hA0A1A2A3A4A5A6A7, 8'hff);
    do_store(1, 2, 64'hB0B1B2B3B4B5B6B7, 8'h0f);
    wait_idle();
    chk(bursts - b0 == 1, "R2 one burst for merged line", bursts - b0, 1);
    chk(last_aw == addr_of(1, 0) && last_len == 2, "R4 burst addr/len", {last_aw, 8'(last_len)}, {addr_of(1, 0), 8'd2});
    chk(last_strb[1] == 8'h00, "R5 empty beat strobe", last_strb[1], 0);
    chk(last_strb[0] == 8'hff && last_strb[2] == 8'h0f, "R5 edge beat strobes",
        {last_strb[0], last_strb[2]}, 16'hff0f);

    // R3: overlapping bytes, newer wins; single-beat burst at beat 3
    do_store(2, 3, 64'h1111111111111111, 8'hff);
    do_store(2, 3, 64'h2222222222222222, 8'h0f);
    wait_idle();
    chk(last_aw == addr_of(2, 3) && last_len == 0, "R4 single beat burst", {last_aw, 8'(last_len)}, {addr_of(2, 3), 8'd0});
    chk({slv_mem[2*32+24+4], slv_mem[2*32+24]} == 16'h1122, "R3 newer bytes replace", {slv_mem[2*32+24+4], slv_mem[2*32+24]}, 16'h1122);

    // R7 full drain, R8, R9, R10
    slave_mode = 0;
    b0 = bursts;
    for (int l = 3; l < 7; l++) do_store(l, 0, {$urandom, $urandom}, 8'hff);
    @(negedge clk); @(negedge clk);
    chk(aw_valid, "R7 full buffer drains early", aw_valid, 1);
    locked_line = int'((aw_addr - BASE) >> 5);
    other = (locked_line == 3) ? 4 : 3;
    probe(7, rdy);
    chk(!rdy, "R8 new line stalls when full", rdy, 0);
    probe(other, rdy);
    chk(rdy, "R8 merge accepted when full", rdy, 1);
    probe(locked_line, rdy);
    chk(!rdy, "R9 draining line stalls", rdy, 0);
    do_store(other, 1, {$urandom, $urandom}, 8'h3c);
    slave_mode = 1;
    wait_idle();
    chk(bursts - b0 == 4, "R2 merge while full adds no burst", bursts - b0, 4);
    probe(locked_line, rdy);
    chk(rdy, "R10 freed line accepted", rdy, 1);

    // random traffic, eight lines over four entries
    slave_mode = 2;
    for (int n = 0; n < 400; n++) begin
      do_store(int'($urandom_range(0, NLINES-1)), int'($urandom_range(0, 3)),
               {$urandom, $urandom}, 8'($urandom_range(1, 255)));
      if ($urandom_range(0, 7) == 0) repeat ($urandom_range(1, 10)) @(negedge clk);
    end
    slave_mode = 1;
    wait_idle();
    chk(!aw_valid && !w_valid && pend == 0, "R7 buffer fully drained", {aw_valid, w_valid}, 0);
    for (int l = 0; l < NLINES; l++) begin
      ok = 1'b1;
      for (int b = 0; b < 32; b++) begin
        if (ok && ref_mem[l*32+b] !== slv_mem[l*32+b]) begin
          ok = 1'b0;
          chk(1'b0, "R3 line contents", slv_mem[l*32+b], ref_mem[l*32+b]);
        end
      end
      if (ok) chk(1'b1, "R3 line contents", 0, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule